// File: doc/BRIEF.md
# Fixed Off-Time Upper-Switch Current Chopper

This block is the digital control for current-mode chopping of the high-side switches of a three-phase half-bridge power stage. Commutation logic supplies one upper-switch enable per phase. An analog comparator raises a flag once the sensed winding current reaches its limit, and a second comparator flag reports whether the drive is in PWM mode or linear mode. The block passes the phase enables on to the upper gate drivers and gates them while an off-time runs.

In PWM mode, a limit trip removes every upper gate for a one-shot off-time. The off-time is counted in block clocks, taken from a software-loaded length input at the moment of the trip, and ends by itself. Each upper turn-on creates a turn-on current spike. To stop that spike from starting a new off-time, a blanking window masks the comparator after every rising edge of a gated upper output.

In linear mode the enables pass straight through, the comparator is ignored, and any pending off-time or blanking is discarded. Two mode-linked outputs go to the power stage: one tells the lower switches to stay fully on, and one selects the fast output slew rate. Both are high in PWM mode and low in linear mode.

Top module: `oneshot_chopper`

## Requirements
- R1: While reset is held, and in the first cycle after it, no off-time is pending. Every gated upper output `up_gate_o[p]` equals `phase_up_en_i[p]`.
- R2: A trip is a cycle in which all of these hold: PWM mode (`pwm_sel_i`=1), at least one phase enabled, no off-time running, no blanking, and `lim_trip_i`=1. From the cycle after a trip, all bits of `up_gate_o` are 0 for exactly N cycles. After that they follow `phase_up_en_i` again.
- R3: N is the value of `off_len_i` sampled in the trip cycle. If that value is 0, N is 1. Changing `off_len_i` while an off-time runs does not change that off-time.
- R4: `lim_trip_i` is ignored while an off-time runs. The off-time is neither extended nor restarted.
- R5: A turn-on event is a cycle in which any bit of `up_gate_o` is 1 and was 0 in the previous cycle. Reset counts as all 0. `lim_trip_i` is ignored in the turn-on cycle and in the BLANK_LEN-1 cycles that follow it.
- R6: With `pwm_sel_i`=0 (linear mode), `up_gate_o` equals `phase_up_en_i`, `lim_trip_i` is ignored, and any pending off-time and blanking are cleared at the next clock edge.
- R7: `low_on_o` and `slew_fast_o` are both 1 when `pwm_sel_i`=1 and both 0 when `pwm_sel_i`=0, in the same cycle.
- R8: A cycle in which all bits of `phase_up_en_i` are 0 clears any pending off-time and blanking at the next clock edge, and `lim_trip_i` has no effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_up_en_i | input | NPH | Upper-switch enables from commutation, one per phase |
| lim_trip_i | input | 1 | Current-limit comparator flag, 1 = limit reached |
| pwm_sel_i | input | 1 | Mode flag, 1 = PWM mode, 0 = linear mode |
| off_len_i | input | OFFW | Off-time length in block clocks, sampled at a trip |
| up_gate_o | output | NPH | Gated upper-switch enables |
| low_on_o | output | 1 | Lower switches held fully on (PWM mode) |
| slew_fast_o | output | 1 | Fast output slew selected (PWM mode) |

## Verification
Trips placed just before, on, and just after the edge of the blanking window show whether masking covers the turn-on cycle plus exactly BLANK_LEN-1 more cycles. Extra trips and changes to the length input during a running off-time show whether the off-time is restarted or its length is re-sampled. Dropping all enables, or switching to linear mode, partway through an off-time shows whether the pending state is actually cleared. A long pseudo-random run then mixes enable rotations, trips, lengths and mode flips, and compares every cycle against a behavioural model.

// File: rtl/chop_pkg.sv
package chop_pkg;

  // Off-time count to load at a trip: a zero length still gives one cycle.
  function automatic logic [31:0] off_load_val(input logic [31:0] len);
    return (len == 32'd0) ? 32'd1 : len;
  endfunction

  // Blanking counter reload: the turn-on cycle itself is masked
  // combinationally, so the counter covers the remaining cycles.
  function automatic logic [31:0] blank_reload(input logic [31:0] blank_len);
    return (blank_len == 32'd0) ? 32'd0 : blank_len - 32'd1;
  endfunction

endpackage

// File: rtl/chop_off_timer.sv
module chop_off_timer #(
  parameter int OFFW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            trip_i,
  input  logic [OFFW-1:0] len_i,
  output logic            off_active_o
);
  import chop_pkg::*;

  logic [OFFW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr_i)       cnt <= '0;
    else if (trip_i)      cnt <= OFFW'(off_load_val(32'(len_i)));
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign off_active_o = (cnt != '0);

  // R2
  trip_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_i && !clr_i) |=> off_active_o);

  // R4
  off_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_active_o && !clr_i) |=> (cnt == $past(cnt) - 1'b1));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !off_active_o);

endmodule

// File: rtl/chop_blank_timer.sv
module chop_blank_timer #(
  parameter int BLANK_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic on_evt_i,
  output logic blank_active_o
);
  import chop_pkg::*;

  localparam int BW = (BLANK_LEN < 2) ? 1 : $clog2(BLANK_LEN + 1);

  logic [BW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr_i)      cnt <= '0;
    else if (on_evt_i)   cnt <= BW'(blank_reload(32'(BLANK_LEN)));
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign blank_active_o = on_evt_i | (cnt != '0);

  // R5
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_evt_i && !clr_i && (BLANK_LEN > 1)) |=> blank_active_o);

endmodule

// File: rtl/chop_gate_mux.sv
module chop_gate_mux #(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] en_i,
  input  logic           pwm_i,
  input  logic           off_active_i,
  output logic [NPH-1:0] gate_o,
  output logic           on_evt_o
);
  logic           hold_off;
  logic [NPH-1:0] gate_q;
  logic [NPH-1:0] rise;

  assign hold_off = pwm_i & off_active_i;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    assign gate_o[p] = en_i[p] & ~hold_off;
    assign rise[p]   = gate_o[p] & ~gate_q[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= gate_o;
  end

  assign on_evt_o = |rise;

endmodule

// File: rtl/oneshot_chopper.sv
module oneshot_chopper #(
  parameter int NPH       = 3,
  parameter int OFFW      = 8,
  parameter int BLANK_LEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPH-1:0]  phase_up_en_i,
  input  logic            lim_trip_i,
  input  logic            pwm_sel_i,
  input  logic [OFFW-1:0] off_len_i,
  output logic [NPH-1:0]  up_gate_o,
  output logic            low_on_o,
  output logic            slew_fast_o
);
  logic any_en;
  logic clr;
  logic off_active;
  logic blank_active;
  logic on_evt;
  logic trip_evt;

  assign any_en   = |phase_up_en_i;
  assign clr      = ~pwm_sel_i | ~any_en;
  assign trip_evt = pwm_sel_i & any_en & ~off_active & ~blank_active & lim_trip_i;

  chop_off_timer #(.OFFW(OFFW)) u_off (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr),
    .trip_i       (trip_evt),
    .len_i        (off_len_i),
    .off_active_o (off_active)
  );

  chop_blank_timer #(.BLANK_LEN(BLANK_LEN)) u_blank (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr_i          (clr),
    .on_evt_i       (on_evt),
    .blank_active_o (blank_active)
  );

  chop_gate_mux #(.NPH(NPH)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (phase_up_en_i),
    .pwm_i        (pwm_sel_i),
    .off_active_i (off_active),
    .gate_o       (up_gate_o),
    .on_evt_o     (on_evt)
  );

  assign low_on_o    = pwm_sel_i;
  assign slew_fast_o = pwm_sel_i;

  // R5
  masked_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_evt && pwm_sel_i && any_en) |=> !off_active);

  // R6
  linear_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_sel_i |=> !off_active);

endmodule

// File: tb/oneshot_chopper_test.sv
module oneshot_chopper_test;
  localparam int NPH = 3;
  localparam int OFFW = 8;
  localparam int BL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPH-1:0] en = '0;
  logic trip = 1'b0;
  logic pwm = 1'b1;
  logic [OFFW-1:0] len = '0;
  logic [NPH-1:0] gate;
  logic low_on, slew_fast;

  int n_chk = 0;
  int n_bad = 0;
  int off_rem = 0;
  int blank_rem = 0;
  logic [NPH-1:0] prev_g = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  oneshot_chopper #(.NPH(NPH), .OFFW(OFFW), .BLANK_LEN(BL)) uut (
    .clk(clk), .rst_n(rst_n), .phase_up_en_i(en), .lim_trip_i(trip),
    .pwm_sel_i(pwm), .off_len_i(len), .up_gate_o(gate),
    .low_on_o(low_on), .slew_fast_o(slew_fast)
  );

  task automatic compare(input string req, input logic [NPH-1:0] eg, input logic em);
    n_chk++;
    if (gate !== eg || low_on !== em || slew_fast !== em) begin
      n_bad++;
      $display("FAIL %s: gate=%b low_on=%b slew=%b expected gate=%b low_on=%b slew=%b",
               req, gate, low_on, slew_fast, eg, em, em);
    end
  endtask

  // One clock: drive inputs after the falling edge, check, then advance the model.
  task automatic cyc(input logic [NPH-1:0] e, input logic t, input logic p,
                     input int l, input string req);
    logic [NPH-1:0] eg;
    bit on, blk, trp;
    @(negedge clk);
    en = e; trip = t; pwm = p; len = OFFW'(l);
    #1;
    eg = (p && off_rem > 0) ? '0 : e;
    compare(req, eg, p);
    on  = ((eg & ~prev_g) != '0);
    blk = (blank_rem > 0) || on;
    trp = p && (e != '0) && (off_rem == 0) && !blk && t;
    if (!p || e == '0) begin
      off_rem = 0; blank_rem = 0;
    end else begin
      if (trp) off_rem = (l == 0) ? 1 : l;
      else if (off_rem > 0) off_rem--;
      if (on) blank_rem = BL - 1;
      else if (blank_rem > 0) blank_rem--;
    end
    prev_g = eg;
  endtask

  task automatic idle(input int n, input logic [NPH-1:0] e, input logic p, input string req);
    for (int i = 0; i < n; i++) cyc(e, 1'b0, p, 5, req);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state, gates follow enable
    en = 3'b001; pwm = 1'b1; trip = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    compare("R1", 3'b001, 1'b1);
    rst_n = 1'b1;
    cyc(3'b001, 1'b0, 1'b1, 5, "R1");

    // R5: trip inside blanking (turn-on was the first cycle after reset)
    cyc(3'b001, 1'b1, 1'b1, 5, "R5");
    cyc(3'b001, 1'b1, 1'b1, 5, "R5");
    idle(3, 3'b001, 1'b1, "R5");

    // R2: clean trip, length 5
    cyc(3'b001, 1'b1, 1'b1, 5, "R2");
    // R4 / R3: trips and length changes during the off-time
    cyc(3'b001, 1'b1, 1'b1, 9, "R4");
    cyc(3'b001, 1'b0, 1'b1, 30, "R3");
    cyc(3'b001, 1'b1, 1'b1, 2, "R4");
    idle(2, 3'b001, 1'b1, "R2");
    // R5: re-turn-on after off-time, trips across the window edge
    for (int i = 0; i < BL + 1; i++) cyc(3'b001, 1'b1, 1'b1, 3, "R5");
    idle(6, 3'b001, 1'b1, "R2");

    // R3: zero length gives one cycle
    cyc(3'b010, 1'b0, 1'b1, 0, "R5");
    idle(BL, 3'b010, 1'b1, "R5");
    cyc(3'b010, 1'b1, 1'b1, 0, "R3");
    idle(BL + 2, 3'b010, 1'b1, "R3");

    // R8: enables dropped mid off-time
    cyc(3'b010, 1'b1, 1'b1, 20, "R8");
    idle(3, 3'b010, 1'b1, "R8");
    cyc(3'b000, 1'b1, 1'b1, 20, "R8");
    idle(3, 3'b100, 1'b1, "R8");

    // R6 / R7: linear mode mid off-time, trips ignored
    idle(BL, 3'b100, 1'b1, "R6");
    cyc(3'b100, 1'b1, 1'b1, 20, "R6");
    idle(2, 3'b100, 1'b1, "R6");
    for (int i = 0; i < 6; i++) cyc(3'b100, 1'b1, 1'b0, 4, "R6");
    cyc(3'b110, 1'b1, 1'b0, 4, "R7");
    cyc(3'b110, 1'b1, 1'b1, 4, "R7");
    idle(8, 3'b110, 1'b1, "R7");

    // R2: pseudo-random mix
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc((lfsr[2:0] == 3'b111) ? 3'b000 : lfsr[2:0], lfsr[5] | lfsr[7],
          (lfsr[11:9] != 3'b000), int'(lfsr[15:12]), "R2");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule